// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that completes each instruction in one clock cycle. It supports a small fixed set of instructions: unsigned add, unsigned subtract, OR with an immediate, word load, word store and branch-on-equal. In one cycle the core fetches, decodes, reads its registers, computes in the ALU, accesses data memory and writes the result back.

The core has two memory ports. The first is a read-only instruction port: the core drives a word address and receives an instruction word back in the same cycle. The second is a data port with an address, write data, a write strobe and a combinational read-data return. The external data memory must update on the rising clock edge when the strobe is high.

Inside the core are a 32-entry register file, the immediate extender, an add/subtract/OR ALU with a zero flag, the next-PC logic and the main decoder. The decoder sends its strobes to the datapath as one packed struct.

Top module: `sc_core`

## Requirements
- R1: `rst` is synchronous and active-high. The edge after which `rst` is sampled high sets `imemAddr` to 0. While `rst` is high, `dmemWe` stays 0.
- R2: Every instruction that is not a taken branch moves the PC forward by 4. `imemAddr` is always word-aligned.
- R3: An instruction with op field [31:26] = 0x00 and funct field [5:0] = 0x21 writes rs+rt into the register selected by rd [15:11]. With funct 0x23 it writes rs−rt into rd. Both wrap modulo 2^32. rs is field [25:21] and rt is field [20:16].
- R4: op 0x0D writes rs OR the zero-extended immediate [15:0] into rt, not into rd.
- R5: op 0x23 loads the word at rs + sign-extended immediate into rt. op 0x2B drives that same address with rt as write data. Negative offsets subtract from rs.
- R6: op 0x04 compares rs and rt through an ALU subtract and its zero flag. When they are equal, the next PC is PC+4+(sign-extended immediate × 4). Otherwise it is PC+4. Backward offsets are supported.
- R7: Register 0 always reads as zero. Writes to it have no effect.
- R8: Any other op value, and op 0x00 with any funct other than 0x21 or 0x23, writes no register, does not strobe memory, and moves the PC forward by 4.
- R9: `dmemWe` is high only in the cycle of a store (op 0x2B).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | 32 | Byte address of the current instruction (the PC) |
| imemData | input | 32 | Instruction word at `imemAddr` |
| dmemAddr | output | 32 | Data address (rs + extended immediate) |
| dmemWdata | output | 32 | Store data (rt) |
| dmemWe | output | 1 | Data write strobe |
| dmemRdata | input | 32 | Combinational read data at `dmemAddr` |

## Verification
The bench builds the core with its default parameters: a 32-bit word and a 5-bit register index. With these values, a subtract that borrows past bit 31 and an immediate with bit 15 set (0x8000) both come within reach. This lets the bench separate zero extension from sign extension and check wrap-around. A 16-word data model is large enough to reach every store address used, including one formed with a negative offset. The instruction model is placed so that a forward branch skips two stores and a backward branch holds the PC on itself.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_OR = 2'd2} aluOp_t;

  typedef struct packed {
    logic   regDst;   // 1: rd, 0: rt
    logic   aluSrc;   // 1: extended immediate, 0: register
    logic   extSign;  // 1: sign-extend, 0: zero-extend
    aluOp_t aluOp;
    logic   memWr;
    logic   memToReg;
    logic   regWr;
    logic   branch;
  } ctrl_t;
endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADDU) begin
          ctrl.regDst = 1'b1;
          ctrl.regWr  = 1'b1;
        end else if (funct == FN_SUBU) begin
          ctrl.regDst = 1'b1;
          ctrl.regWr  = 1'b1;
          ctrl.aluOp  = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl.aluSrc = 1'b1;
        ctrl.aluOp  = ALU_OR;
        ctrl.regWr  = 1'b1;
      end
      OP_LW: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.extSign  = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.regWr    = 1'b1;
      end
      OP_SW: begin
        ctrl.aluSrc  = 1'b1;
        ctrl.extSign = 1'b1;
        ctrl.memWr   = 1'b1;
      end
      OP_BEQ: begin
        ctrl.extSign = 1'b1;
        ctrl.aluOp   = ALU_SUB;
        ctrl.branch  = 1'b1;
      end
      default: ;
    endcase
    if (rst) begin
      ctrl.regWr = 1'b0;
      ctrl.memWr = 1'b0;
    end
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [XLEN-1:0]   rdDataA,
  output logic [XLEN-1:0]   rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [XLEN-1:0]   wrData
);
  localparam int REG_COUNT = 1 << ADDR_W;

  logic [XLEN-1:0] regs [REG_COUNT];

  // Entry 0 is left without storage; entries above it hold state.
  assign regs[0] = '0;
  for (genvar i = 1; i < REG_COUNT; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (wrEn && wrAddr == ADDR_W'(i)) regs[i] <= wrData;
    end
  end

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  aluOp_t          op,
  output logic [XLEN-1:0] result,
  output logic            zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: result = opA - opB;
      ALU_OR:  result = opA | opB;
      default: result = opA + opB;
    endcase
  end
  assign zero = (result == '0);
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrl,
  input  logic [25:0]     instrLow,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] dmemAddr,
  output logic [XLEN-1:0] dmemWdata,
  input  logic [XLEN-1:0] dmemRdata
);
  localparam int IMM_W = 16;

  logic [ADDR_W-1:0] rsIdx, rtIdx, rdIdx, wrIdx;
  logic [IMM_W-1:0]  imm;
  logic [XLEN-1:0]   busA, busB, extImm, aluB, aluY, wrData;
  logic [XLEN-1:0]   pcPlus4, branchTarget, pcNext;
  logic              aluZero;

  assign rsIdx = instrLow[25:21];
  assign rtIdx = instrLow[20:16];
  assign rdIdx = instrLow[15:11];
  assign imm   = instrLow[15:0];

  assign extImm = {{(XLEN-IMM_W){ctrl.extSign & imm[IMM_W-1]}}, imm};
  assign wrIdx  = ctrl.regDst ? rdIdx : rtIdx;
  assign aluB   = ctrl.aluSrc ? extImm : busB;
  assign wrData = ctrl.memToReg ? dmemRdata : aluY;

  sc_regfile #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rdAddrA(rsIdx), .rdAddrB(rtIdx),
    .rdDataA(busA), .rdDataB(busB),
    .wrEn(ctrl.regWr), .wrAddr(wrIdx), .wrData(wrData)
  );

  sc_alu #(.XLEN(XLEN)) u_alu (
    .opA(busA), .opB(aluB), .op(ctrl.aluOp), .result(aluY), .zero(aluZero)
  );

  assign dmemAddr     = aluY;
  assign dmemWdata    = busB;
  assign pcPlus4      = pc + XLEN'(4);
  assign branchTarget = pcPlus4 + {extImm[XLEN-3:0], 2'b00};
  assign pcNext       = (ctrl.branch && aluZero) ? branchTarget : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imemAddr,
  input  logic [31:0]     imemData,
  output logic [XLEN-1:0] dmemAddr,
  output logic [XLEN-1:0] dmemWdata,
  output logic            dmemWe,
  input  logic [XLEN-1:0] dmemRdata
);
  ctrl_t ctrl;

  sc_control u_ctrl (
    .rst(rst), .opcode(imemData[31:26]), .funct(imemData[5:0]), .ctrl(ctrl)
  );

  sc_datapath #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .instrLow(imemData[25:0]),
    .pc(imemAddr), .dmemAddr(dmemAddr), .dmemWdata(dmemWdata),
    .dmemRdata(dmemRdata)
  );

  assign dmemWe = ctrl.memWr;
endmodule

// File: rtl/sc_core_checker.sv
module sc_core_checker
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] imemAddr,
  input logic [31:0] imemData,
  input logic [31:0] dmemWdata,
  input logic        dmemWe
);
  logic [31:0] brOff;
  assign brOff = {{14{imemData[15]}}, imemData[15:0], 2'b00};

  AST_RESET_PC: assert property (@(posedge clk) rst |=> imemAddr == 32'd0); // R1
  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) rst |-> !dmemWe); // R1
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst) imemAddr[1:0] == 2'b00); // R2
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    imemData[31:26] != OP_BEQ |=> imemAddr == $past(imemAddr) + 32'd4); // R2 R8
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    imemData[31:26] == OP_BEQ |=> (imemAddr == $past(imemAddr) + 32'd4) ||
                                  (imemAddr == $past(imemAddr) + 32'd4 + $past(brOff))); // R6
  AST_STORE_ONLY_SW: assert property (@(posedge clk) disable iff (rst)
    dmemWe |-> imemData[31:26] == OP_SW); // R9
  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
    dmemWe && imemData[20:16] == 5'd0 |-> dmemWdata == 32'd0); // R7
endmodule

bind sc_core sc_core_checker u_chk (.*);

// File: tb/sc_core_bench.sv
module sc_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWdata, dmemRdata;
  logic        dmemWe;
  logic [31:0] imem [32];
  logic [31:0] dmem [16];
  int          nChecks = 0;
  int          nFails  = 0;
  bit          finished = 1'b0;

  typedef struct { logic [31:0] pc; string tag; } pcItem_t;
  typedef struct { logic [31:0] addr; logic [31:0] data; string tag; } stItem_t;
  pcItem_t pcQ[$];
  stItem_t stQ[$];

  always #2.5 clk = ~clk;

  sc_core u_sc_core (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWdata(dmemWdata), .dmemWe(dmemWe),
    .dmemRdata(dmemRdata)
  );

  assign imemData  = imem[imemAddr[6:2]];
  assign dmemRdata = dmem[dmemAddr[5:2]];
  always_ff @(posedge clk) if (dmemWe) dmem[dmemAddr[5:2]] <= dmemWdata;

  function automatic logic [31:0] encR(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(input logic [5:0] op, input logic [4:0] rs, rt,
                                       input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expPc(input logic [31:0] pc, input string tag);
    pcQ.push_back('{pc, tag});
  endtask
  task automatic expStore(input logic [31:0] a, d, input string tag);
    stQ.push_back('{a, d, tag});
  endtask

  // Monitor: compares the PC and any store against the scoreboard each cycle.
  always @(negedge clk) begin
    if (!rst && pcQ.size() > 0) begin
      pcItem_t p;
      p = pcQ.pop_front();
      check({p.tag, " pc"}, imemAddr, p.pc);
      if (dmemWe) begin
        if (stQ.size() == 0) check("R9 unexpected store", 32'd1, 32'd0);
        else begin
          stItem_t s;
          s = stQ.pop_front();
          check({s.tag, " addr"}, dmemAddr, s.addr);
          check({s.tag, " data"}, dmemWdata, s.data);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) imem[i] = 32'd0;
    for (int i = 0; i < 16; i++) dmem[i] = 32'd0;
    imem[0]  = encI(6'h0D, 0, 1, 16'h1234);       // r1 = 0x1234        R4
    imem[1]  = encI(6'h0D, 0, 2, 16'h8000);       // r2 = 0x8000 (zero-ext) R4
    imem[2]  = encR(1, 2, 3, 6'h21);              // r3 = 0x9234        R3
    imem[3]  = encR(1, 2, 4, 6'h23);              // r4 = 0xFFFF9234    R3
    imem[4]  = encI(6'h2B, 0, 3, 16'd0);
    imem[5]  = encI(6'h2B, 0, 4, 16'd4);
    imem[6]  = encI(6'h0D, 0, 5, 16'h0010);       // r5 = 16
    imem[7]  = encI(6'h2B, 5, 2, 16'hFFFC);       // store at 16-4 = 12  R5
    imem[8]  = encI(6'h23, 0, 6, 16'd4);          // r6 = mem[4]
    imem[9]  = encI(6'h2B, 0, 6, 16'd8);
    imem[10] = encI(6'h0D, 1, 0, 16'h0005);       // write to r0        R7
    imem[11] = encI(6'h2B, 0, 0, 16'd16);
    imem[12] = encI(6'h04, 3, 4, 16'd5);          // not taken          R6
    imem[13] = encI(6'h04, 6, 4, 16'd2);          // taken -> 64        R6
    imem[14] = encI(6'h2B, 0, 1, 16'd20);         // skipped
    imem[15] = encI(6'h2B, 0, 1, 16'd20);         // skipped
    imem[16] = encI(6'h3F, 1, 7, 16'h00FF);       // unknown op         R8
    imem[17] = encI(6'h2B, 0, 7, 16'd24);
    imem[18] = encR(1, 1, 8, 6'h25);              // unknown funct      R8
    imem[19] = encI(6'h2B, 0, 8, 16'd28);
    imem[20] = encI(6'h04, 0, 0, 16'hFFFF);       // branch to self     R6

    for (int i = 0; i <= 13; i++) expPc(32'(i * 4), "R2");
    expPc(32'd64, "R6 taken");
    expPc(32'd68, "R8 op");
    expPc(32'd72, "R8");
    expPc(32'd76, "R8 funct");
    for (int i = 0; i < 4; i++) expPc(32'd80, "R6 backward");
    expStore(32'd0,  32'h0000_9234, "R3 addu");
    expStore(32'd4,  32'hFFFF_9234, "R3 subu wrap");
    expStore(32'd12, 32'h0000_8000, "R5 neg offset R4 zero-ext");
    expStore(32'd8,  32'hFFFF_9234, "R5 load");
    expStore(32'd16, 32'd0,         "R7 r0 write ignored");
    expStore(32'd24, 32'd0,         "R8 unknown op no write");
    expStore(32'd28, 32'd0,         "R8 unknown funct no write");

    repeat (3) begin
      @(negedge clk);
      check("R1 reset pc", imemAddr, 32'd0);
      check("R1 no store in reset", {31'd0, dmemWe}, 32'd0);
    end
    @(posedge clk); #1 rst = 1'b0;
    wait (pcQ.size() == 0);
    @(negedge clk);
    check("R9 all stores seen", 32'(stQ.size()), 32'd0);
    check("R6 still looping", imemAddr, 32'd80);

    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-run reset pc", imemAddr, 32'd0);
    check("R1 no store in reset", {31'd0, dmemWe}, 32'd0);
    expPc(32'd0, "R1 restart");
    expPc(32'd4, "R2 restart");
    expPc(32'd8, "R2 restart");
    @(posedge clk); #1 rst = 1'b0;
    wait (pcQ.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule